// File: doc/BRIEF.md
# Packet-Aware FIFO with Availability Flag

This block is a single-clock FIFO that sits in front of a packet transmitter. Each stored word carries a data field and two marker bits: start of packet and end of packet. A writer pushes words under backpressure from a full flag. A reader pops words from the head, and the head word is always visible on the read side. A separate availability output tells the transmitter when it may start a transfer. The aim is that a transfer, once started, runs without gaps in its data.

Normally the block raises availability only when at least one complete packet is stored. A packet counts as complete once its end-of-packet word has been written. The flag stays up until the last stored end-of-packet word has been read. Some packets are too large to hold whole. For these, an optional override raises availability when the fill level reaches a high threshold. It then keeps the flag up until the level falls below a low threshold. This hysteresis lets a long packet start early, and a low threshold of at least one burst means the reader is not starved partway through a burst.

Top module: `pkt_avail_fifo`

## Requirements
- R1: After a synchronous active-low reset, the FIFO is empty. `rd_empty` is 1, and `wr_full` and `avail` are both 0.
- R2: A write is accepted only while `wr_full` is 0. `wr_full` is 1 exactly when DEPTH words are stored. A write attempted while full changes nothing, and no extra word appears at the read side.
- R3: A read is accepted only while `rd_empty` is 0, and words leave in the order they were written. `rd_data`, `rd_sop` and `rd_eop` show the head word in the same cycle. A read attempted while empty changes nothing.
- R4: `avail` is 1 in every cycle in which at least one stored word has its end-of-packet marker set. The flag rises right after the clock edge that accepts such a word.
- R5: With the override off, `avail` stays 1 until the clock edge that reads out the last stored end-of-packet word. It is 0 after that edge.
- R6: If an end-of-packet word is written and another is read in the same cycle, the count of complete packets does not change, and neither does `avail`.
- R7: When `ovr_en` is 1 and the fill level is at least `hi_thr`, `avail` is 1 even if no end-of-packet word is stored.
- R8: Once the override has raised `avail`, it keeps the flag up while the level stays at or above `lo_thr`. When the level drops below `lo_thr`, `avail` falls unless an end-of-packet word is stored. Configuration must satisfy `hi_thr` > `lo_thr`.
- R9: With `lo_thr` equal to 0, an override hold lasts until the FIFO is completely empty. `avail` is never 1 while `rd_empty` is 1.
- R10: When `ovr_en` is 0, the threshold inputs have no effect. A full FIFO that holds no end-of-packet word keeps `avail` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_sop | input | 1 | Start-of-packet marker for the written word |
| wr_eop | input | 1 | End-of-packet marker for the written word |
| wr_full | output | 1 | FIFO holds DEPTH words; writes are refused |
| rd_en | input | 1 | Read request (pops the head word) |
| rd_data | output | DATA_W | Head word data |
| rd_sop | output | 1 | Head word start-of-packet marker |
| rd_eop | output | 1 | Head word end-of-packet marker |
| rd_empty | output | 1 | FIFO holds no word; reads are refused |
| avail | output | 1 | Transmitter may start a transfer |
| ovr_en | input | 1 | Enables the threshold override |
| hi_thr | input | LVL_W | Fill level, in words, that raises the override |
| lo_thr | input | LVL_W | Fill level, in words, below which the override releases |

## Verification
All flags and the head word are driven by logic that reads only registered state. As a result, `wr_full`, `rd_empty` and `avail` take their new values at the same rising edge that accepts a write or a read, with no extra cycle of delay. The head word for a given read is valid before that edge. The bench drives inputs at the falling edge and checks the head word against its queue model before the rising edge. It updates the model at the rising edge, then compares all three flags at the next falling edge. This way every result is sampled half a period after the edge on which it is due.

// File: rtl/pkt_fifo_pkg.sv
// Package: shared marker type for the packet FIFO.
// Assumes: marker bits are packed below the data field in each stored word.
package pkt_fifo_pkg;

    // Start and end-of-packet markers carried with every word.
    typedef struct packed {
        logic sop;
        logic eop;
    } pf_mark_t;

    localparam int MARK_W = $bits(pf_mark_t);

endpackage

// File: rtl/pf_store.sv
// Module: pf_store
// Circular word storage with write/read handshakes and a fill level.
// Assumes: DEPTH >= 2; the head word is shown combinationally (show-ahead).
module pf_store #(
    parameter int WORD_W = 18,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_req,
    output logic [WORD_W-1:0] head_word,
    output logic              wr_acc,
    output logic              rd_acc,
    output logic              full,
    output logic              empty,
    output logic [LW-1:0]     level
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q;
    logic [AW-1:0]     rptr_q;
    logic [LW-1:0]     level_q;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + AW'(1);
    endfunction

    // Status and handshake acceptance from registered level.
    always_comb begin
        full      = (level_q == LW'(DEPTH));
        empty     = (level_q == '0);
        wr_acc    = wr_req && !full;
        rd_acc    = rd_req && !empty;
        level     = level_q;
        head_word = mem[rptr_q];
    end

    // Store accepted words (array itself is not reset).
    always_ff @(posedge clk) begin
        if (wr_acc) mem[wptr_q] <= wr_word;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_q <= '0;
        end else begin
            if (wr_acc) wptr_q <= bump(wptr_q);
            if (rd_acc) rptr_q <= bump(rptr_q);
            case ({wr_acc, rd_acc})
                2'b10:   level_q <= level_q + LW'(1);
                2'b01:   level_q <= level_q - LW'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R2
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_req) |=> full); // R2
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_req) |=> empty); // R3
    AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_acc && !rd_acc) |=> $stable(level)); // R3

endmodule

// File: rtl/pf_eop_count.sv
// Module: pf_eop_count
// Up/down counter of end-of-packet words held in storage.
// Assumes: caller only decrements when a stored EOP word really leaves.
module pf_eop_count #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          any
);

    logic [CW-1:0] cnt_q;

    // Count up on EOP write, down on EOP read, hold if both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Expose count and non-zero flag.
    always_comb begin
        cnt = cnt_q;
        any = (cnt_q != '0);
    end

    AST_EOP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !(dec && !inc)); // R5
    AST_EOP_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt)); // R6

endmodule

// File: rtl/pf_thresh.sv
// Module: pf_thresh
// Hysteretic fill-level override: sets at the high mark, releases below the low mark
// or when storage is empty. Assumes hi > lo is kept by configuration.
module pf_thresh #(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovr_en,
    input  logic [LW-1:0] hi,
    input  logic [LW-1:0] lo,
    input  logic [LW-1:0] level,
    output logic          hold
);

    logic held_q;
    logic at_high;
    logic keep;

    // Decide hold from current level and previous hold state.
    always_comb begin
        at_high = (level >= hi);
        keep    = held_q && (level >= lo) && (level != '0);
        hold    = ovr_en && (at_high || keep);
    end

    // Remember whether the override was active.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= hold;
    end

    AST_HOLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_en |-> !hold); // R10
    AST_HOLD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && hi > lo) |-> !hold); // R9

endmodule

// File: rtl/pkt_avail_fifo.sv
// Module: pkt_avail_fifo (top)
// Packet FIFO raising 'avail' when a complete packet is stored, or through a
// hysteretic threshold override. Assumes single clock, hi_thr > lo_thr.
module pkt_avail_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int WORD_W = DATA_W + MARK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    output logic              wr_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic              rd_empty,
    output logic              avail,
    input  logic              ovr_en,
    input  logic [LVL_W-1:0]  hi_thr,
    input  logic [LVL_W-1:0]  lo_thr
);

    pf_mark_t          wr_mark;
    pf_mark_t          head_mark;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] head_word;
    logic              wr_acc;
    logic              rd_acc;
    logic              full;
    logic              empty;
    logic [LVL_W-1:0]  level;
    logic [LVL_W-1:0]  eop_cnt;
    logic              eop_any;
    logic              thr_hold;

    // Pack the write word and unpack the head word.
    always_comb begin
        wr_mark.sop = wr_sop;
        wr_mark.eop = wr_eop;
        wr_word     = {wr_data, wr_mark};
        head_mark   = head_word[MARK_W-1:0];
        rd_data     = head_word[WORD_W-1:MARK_W];
        rd_sop      = head_mark.sop;
        rd_eop      = head_mark.eop;
        wr_full     = full;
        rd_empty    = empty;
        avail       = eop_any || thr_hold;
    end

    pf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_valid),
        .wr_word   (wr_word),
        .rd_req    (rd_en),
        .head_word (head_word),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .full      (full),
        .empty     (empty),
        .level     (level)
    );

    pf_eop_count #(.CW(LVL_W)) u_eop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wr_acc && wr_eop),
        .dec   (rd_acc && head_mark.eop),
        .cnt   (eop_cnt),
        .any   (eop_any)
    );

    pf_thresh #(.LW(LVL_W)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovr_en (ovr_en),
        .hi     (hi_thr),
        .lo     (lo_thr),
        .level  (level),
        .hold   (thr_hold)
    );

    AST_EOP_LE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        eop_cnt <= level); // R4
    AST_EOP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && wr_eop) |=> avail); // R4
    AST_NO_AVAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && hi_thr > lo_thr) |-> !avail); // R9
    AST_PLAIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en && eop_cnt == LVL_W'(1) && rd_acc && rd_eop && !(wr_acc && wr_eop)
         && !$changed(ovr_en)) |=> !avail); // R5

endmodule

// File: tb/pkt_avail_fifo_tb.sv
module pkt_avail_fifo_tb;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 1024;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_sop = 1'b0;
    logic              wr_eop = 1'b0;
    logic              wr_full;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_sop;
    logic              rd_eop;
    logic              rd_empty;
    logic              avail;
    logic              ovr_en = 1'b0;
    logic [LVL_W-1:0]  hi_thr = LVL_W'(24);
    logic [LVL_W-1:0]  lo_thr = LVL_W'(8);

    int errors = 0;
    int checks = 0;

    logic [17:0] q[$];
    int  m_eop  = 0;
    bit  m_held = 1'b0;

    always #2.5 clk = ~clk;

    pkt_avail_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_full(wr_full), .rd_en(rd_en),
        .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_empty(rd_empty),
        .avail(avail), .ovr_en(ovr_en), .hi_thr(hi_thr), .lo_thr(lo_thr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Override hold as stated by R7, R8, R9, R10.
    function automatic bit hold_fn(input int lvl, input bit held);
        return ovr_en && ((lvl >= int'(hi_thr)) ||
                          (held && lvl >= int'(lo_thr) && lvl != 0));
    endfunction

    function automatic bit exp_avail();
        return (m_eop > 0) || hold_fn(q.size(), m_held);
    endfunction

    // One clock: drive at negedge, update model at posedge, check at next negedge.
    task automatic step(input bit wv, input logic [15:0] wd, input bit ws, input bit we, input bit re);
        bit wacc, racc, hp;
        wr_valid = wv; wr_data = wd; wr_sop = ws; wr_eop = we; rd_en = re;
        wacc = wv && (q.size() < DEPTH);
        racc = re && (q.size() > 0);
        if (racc) chk("R3 head word", {14'd0, rd_data, rd_sop, rd_eop}, {14'd0, q[0]});
        hp = hold_fn(q.size(), m_held);
        @(posedge clk);
        m_held = hp;
        if (racc) begin
            if (q[0][0]) m_eop--;
            void'(q.pop_front());
        end
        if (wacc) begin
            q.push_back({wd, ws, we});
            if (we) m_eop++;
        end
        @(negedge clk);
        wr_valid = 1'b0; rd_en = 1'b0;
        chk("R2 full", wr_full, q.size() == DEPTH);
        chk("R3 empty", rd_empty, q.size() == 0);
        if (m_eop > 0)   chk("R4 avail", avail, exp_avail());
        else if (!ovr_en) chk("R10 avail", avail, exp_avail());
        else             chk("R8 avail", avail, exp_avail());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", rd_empty, 1);
        chk("R1 full", wr_full, 0);
        chk("R1 avail", avail, 0);

        // R4/R5: three-word packet
        step(1, 16'h1111, 1, 0, 0);
        chk("R4 no eop yet", avail, 0);
        step(1, 16'h2222, 0, 0, 0);
        step(1, 16'h3333, 0, 1, 0);
        chk("R4 eop stored", avail, 1);
        step(1, 16'h4444, 1, 1, 0);       // second packet
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);              // first EOP leaves
        chk("R5 second packet holds", avail, 1);
        // R6: EOP write and EOP read same cycle
        step(1, 16'h5555, 1, 1, 1);
        chk("R6 simultaneous", avail, 1);
        step(0, 0, 0, 0, 1);
        chk("R5 last eop read", avail, 0);
        step(0, 0, 0, 0, 1);              // R3 read on empty ignored
        chk("R3 empty read", rd_empty, 1);

        // R7/R8 override hysteresis
        ovr_en = 1; hi_thr = 24; lo_thr = 8;
        for (int i = 0; i < 23; i++) step(1, 16'(i), 0, 0, 0);
        chk("R7 below high", avail, 0);
        step(1, 16'h0A0A, 0, 0, 0);
        chk("R7 at high", avail, 1);
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 1);
        chk("R8 at low", avail, 1);
        step(0, 0, 0, 0, 1);
        chk("R8 below low", avail, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1);

        // R9 low threshold zero drains fully
        hi_thr = 4; lo_thr = 0;
        for (int i = 0; i < 4; i++) step(1, 16'(i), 0, 0, 0);
        chk("R9 raised", avail, 1);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);
        chk("R9 one left", avail, 1);
        step(0, 0, 0, 0, 1);
        chk("R9 empty drop", avail, 0);

        // R10 + R2: override off, fill past full with no EOP
        ovr_en = 0; hi_thr = 2; lo_thr = 1;
        for (int i = 0; i < DEPTH + 6; i++) step(1, 16'(i), 0, 0, 0);
        chk("R2 full", wr_full, 1);
        chk("R10 no avail", avail, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1);
        chk("R2 extra dropped", rd_empty, 1);

        // Random mix
        for (int seg = 0; seg < 6; seg++) begin
            ovr_en = seg[0];
            hi_thr = LVL_W'(8 + $urandom_range(0, 120));
            lo_thr = LVL_W'($urandom_range(0, int'(hi_thr) - 1));
            for (int i = 0; i < 600; i++) begin
                step($urandom_range(0, 99) < 60, 16'($urandom),
                     $urandom_range(0, 7) == 0, $urandom_range(0, 9) == 0,
                     $urandom_range(0, 99) < (seg < 3 ? 35 : 55));
            end
        end
        while (q.size() > 0) step(0, 0, 0, 0, 1);
        chk("R3 drained", rd_empty, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule